// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-slave entry point of a page-buffered flash device. It oversamples the serial clock, chip select and data-in lines with the system clock. While chip select is low it captures data-in on every serial-clock rising edge. An 8-bit opcode comes first, most significant bit first. For a recognised array, buffer or program command the opcode is followed by a 24-bit address word. When the last address bit arrives the block issues a one-cycle command strobe. The strobe carries the opcode, the 9-bit page number and the 9-bit byte/buffer offset. The array engine behind it acts on that strobe and does all data movement.

Status requests are answered inside the block. The status byte is driven on the serial output changing on serial-clock falling edges. It is sent again, freshly sampled, for as long as chip select stays low. The serial clock may rest high or low when chip select falls, and both cases frame commands the same way. A chip-select rise always produces a one-cycle event pulse. If that rise comes early it cancels a partly received command.

The control is one state machine with six states:
- IDLE goes to OPCODE when chip select is low.
- OPCODE goes to STATUS for a status opcode, to ADDRESS for a known command opcode, or to DISCARD otherwise.
- ADDRESS goes to HOLD after the last address bit, firing the strobe.
- STATUS, HOLD and DISCARD stay where they are.
- Every state returns to IDLE when chip select goes high.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, `so_en`, `cmd_valid` and `cs_rise` are all 0.
- R2: Bits on `si` are taken on `sck` rising edges while `cs_n` is low, opcode MSB first. A frame gives the same result whether `sck` rests low or high when `cs_n` falls.
- R3: After the 8 opcode bits and 24 address bits of a known command, `cmd_valid` pulses. The address word is sent MSB first. Its upper 6 bits are ignored, bits 17:9 appear on `cmd_page` and bits 8:0 appear on `cmd_byte`.
- R4: The known command opcodes are:
  - read opcodes 68h, E8h, 52h, D2h, 54h and D4h;
  - transfer and rewrite opcodes 53h and 58h;
  - program opcodes 82h, 83h, 84h and 88h.
  - Only these produce a strobe.
- R5: After opcode 57h or D7h, `so_en` rises at the first `sck` falling edge after the eighth rising edge. The status bits then appear on `so` MSB first, advancing on each falling edge. `so_en` is back at 0 within 2 clocks of the `cs_rise` pulse.
- R6: The status byte layout is:
  - bit 7 is `dev_ready`;
  - bit 6 is `cmp_miss`;
  - bits 5:2 are `density`;
  - bits 1:0 are 0.
- R7: While `cs_n` stays low, the status byte repeats. Each repeat takes its value from the inputs at the falling edge that starts that byte, so changes in the middle of a byte do not affect it.
- R8: An unknown opcode gives no strobe, and `so_en` stays 0 until `cs_n` rises. The next frame decodes normally.
- R9: If `cs_n` rises before all 24 address bits have arrived, the command is dropped without a strobe.
- R10: `cs_rise` pulses for exactly one clock on every rise of `cs_n`.
- R11: `cmd_valid` lasts one clock. `cmd_opcode`, `cmd_page` and `cmd_byte` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| dev_ready | input | 1 | Device ready (1) / busy (0) |
| cmp_miss | input | 1 | Result of the last page compare |
| density | input | 4 | Density code |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable; 0 means the pad is high impedance |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Opcode of the strobed command |
| cmd_page | output | PAGE_W | Page number of the strobed command |
| cmd_byte | output | BYTE_W | Byte/buffer offset of the strobed command |
| cs_rise | output | 1 | One-cycle pulse on chip-select rise |

## Verification
The bench sends full commands with the serial clock resting low and resting high, using opcodes from both members of an opcode pair. This separates correct edge selection from accidental sampling on falling edges. Multi-byte status reads change the ready and density inputs in the middle of a byte, which separates a per-byte latch from a live feed-through. An unknown opcode followed by a full-length tail, and a known opcode cut short after ten address bits, show that only a complete, recognised frame strobes. The held output fields are checked after that cancelled frame.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_STATUS,
        ST_HOLD,
        ST_DISCARD
    } fc_state_e;

    function automatic logic op_is_status(input logic [OPC_W-1:0] op);
        return (op == 8'h57) || (op == 8'hD7);
    endfunction

    function automatic logic op_is_known(input logic [OPC_W-1:0] op);
        unique case (op)
            8'h68, 8'hE8, 8'h52, 8'hD2, 8'h54, 8'hD4,
            8'h53, 8'h58, 8'h82, 8'h83, 8'h84, 8'h88: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input logic rdy,
                                               input logic miss,
                                               input logic [3:0] dens);
        return {rdy, miss, dens, 2'b00};
    endfunction

endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= RST_VAL;
            end else if (g == 0) begin
                chain[g] <= d;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fsc_status_tx.sv
module fsc_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       shift_ev,
    input  logic [7:0] status_in,
    output logic       so,
    output logic       so_en
);
    logic [7:0] sh_q;
    logic [2:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            so_en <= 1'b0;
        end else if (!active) begin
            idx_q <= '0;
            so_en <= 1'b0;
        end else if (shift_ev) begin
            so_en <= 1'b1;
            idx_q <= idx_q + 3'd1;
            sh_q  <= (idx_q == 3'd0) ? status_in : {sh_q[6:0], 1'b0};
        end
    end

    assign so = sh_q[7];
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RSV_W       = 6,
    parameter int PAGE_W      = 9,
    parameter int BYTE_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              dev_ready,
    input  logic              cmp_miss,
    input  logic [3:0]        density,
    output logic              so,
    output logic              so_en,
    output logic              cmd_valid,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [PAGE_W-1:0] cmd_page,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cs_rise
);
    localparam int ADDR_W = RSV_W + PAGE_W + BYTE_W;
    localparam int CNT_W  = $clog2(ADDR_W);

    // synchronised serial lines, order {cs_n, sck, si}
    logic [2:0] sync_q;
    fsc_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     (sync_q)
    );

    logic cs_act, sck_s, si_s, sck_d, cs_act_d;
    logic sck_rise, sck_fall;
    assign cs_act = ~sync_q[2];
    assign sck_s  = sync_q[1];
    assign si_s   = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            cs_act_d <= 1'b0;
        end else begin
            sck_d    <= sck_s;
            cs_act_d <= cs_act;
        end
    end

    assign sck_rise = cs_act &  sck_s & ~sck_d;
    assign sck_fall = cs_act & ~sck_s &  sck_d;

    fc_state_e         state_q, state_nx;
    logic [ADDR_W-1:0] sh_q, shifted;
    logic [CNT_W-1:0]  cnt_q;
    logic [OPC_W-1:0]  op_q;
    logic              op_done, addr_done;

    assign shifted   = {sh_q[ADDR_W-2:0], si_s};
    assign op_done   = (state_q == ST_OPCODE)  && sck_rise && (cnt_q == CNT_W'(OPC_W-1));
    assign addr_done = (state_q == ST_ADDRESS) && sck_rise && (cnt_q == CNT_W'(ADDR_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_act) state_nx = ST_OPCODE;
            ST_OPCODE:  if (op_done) begin
                            if (op_is_status(shifted[OPC_W-1:0]))     state_nx = ST_STATUS;
                            else if (op_is_known(shifted[OPC_W-1:0])) state_nx = ST_ADDRESS;
                            else                                      state_nx = ST_DISCARD;
                        end
            ST_ADDRESS: if (addr_done) state_nx = ST_HOLD;
            ST_STATUS, ST_HOLD, ST_DISCARD: state_nx = state_q;
            default:    state_nx = ST_IDLE;
        endcase
        if (!cs_act) state_nx = ST_IDLE;
    end

    // shift path and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            op_q  <= '0;
        end else begin
            if (state_q == ST_IDLE || op_done) begin
                cnt_q <= '0;
            end else if (sck_rise && (state_q == ST_OPCODE || state_q == ST_ADDRESS)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (sck_rise && (state_q == ST_OPCODE || state_q == ST_ADDRESS)) begin
                sh_q <= shifted;
            end
            if (op_done) op_q <= shifted[OPC_W-1:0];
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_page   <= '0;
            cmd_byte   <= '0;
            cs_rise    <= 1'b0;
        end else begin
            cmd_valid <= addr_done;
            cs_rise   <= cs_act_d & ~cs_act;
            if (addr_done) begin
                cmd_opcode <= op_q;
                cmd_page   <= shifted[BYTE_W +: PAGE_W];
                cmd_byte   <= shifted[BYTE_W-1:0];
            end
        end
    end

    fsc_status_tx u_stx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_STATUS),
        .shift_ev  (sck_fall),
        .status_in (pack_status(dev_ready, cmp_miss, density)),
        .so        (so),
        .so_en     (so_en)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input fc_state_e  state,
    input logic       sck_fall,
    input logic       cmd_valid,
    input logic [7:0] cmd_opcode,
    input logic       so_en,
    input logic       cs_rise
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R11

    AST_STROBE_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> op_is_known(cmd_opcode)); // R4

    AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(state) == ST_ADDRESS); // R3

    AST_SO_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(sck_fall)); // R5

    AST_SO_OFF_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_en); // R5

    AST_CS_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !cs_rise); // R10
endmodule

bind flash_cmd_front fsc_checker u_fsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .sck_fall   (sck_fall),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .so_en      (so_en),
    .cs_rise    (cs_rise)
);

// File: tb/flash_cmd_front_bench.sv
module flash_cmd_front_bench;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       dev_ready = 1'b1, cmp_miss = 1'b0;
    logic [3:0] density = 4'b0011;
    logic       so, so_en, cmd_valid, cs_rise;
    logic [7:0] cmd_opcode;
    logic [8:0] cmd_page, cmd_byte;

    always #2.5 clk = ~clk;

    flash_cmd_front u_flash_cmd_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .dev_ready(dev_ready), .cmp_miss(cmp_miss), .density(density),
        .so(so), .so_en(so_en), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_page(cmd_page), .cmd_byte(cmd_byte), .cs_rise(cs_rise)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [8:0] page;
        logic [8:0] byt;
    } exp_t;

    exp_t  exp_q[$];
    int    n_cmp = 0, n_bad = 0, n_csr = 0;
    string cur_tag = "R3";
    bit    idle_hi = 1'b0;
    bit    en_seen = 1'b0;
    bit    prev_valid = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: pops expected strobes and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                chk(!prev_valid, "R11 strobe width", 32'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected strobe"}, 32'(cmd_opcode), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cmd_opcode == e.op,  "R3 opcode", 32'(cmd_opcode), 32'(e.op));
                    chk(cmd_page == e.page,  "R3 page",   32'(cmd_page),   32'(e.page));
                    chk(cmd_byte == e.byt,   "R3 byte",   32'(cmd_byte),   32'(e.byt));
                end
            end
            prev_valid = cmd_valid;
            if (cs_rise) n_csr++;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        sck = idle_hi;
        wclk(4);
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_end();
        wclk(HALF);
        cs_n = 1'b1;
        wclk(12);
        sck = 1'b0;
        wclk(4);
    endtask

    task automatic bit_x(input logic b, output logic so_v);
        if (idle_hi) sck = 1'b0;
        si = b;
        wclk(HALF);
        so_v = so;
        if (so_en) en_seen = 1'b1;
        sck = 1'b1;
        wclk(HALF);
        if (!idle_hi) sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic d;
        for (int i = n - 1; i >= 0; i--) bit_x(v[i], d);
    endtask

    task automatic cmd_frame(input logic [7:0] op, input logic [23:0] addr, input int nbits, input bit expect_strobe);
        if (expect_strobe) exp_q.push_back('{op: op, page: addr[17:9], byt: addr[8:0]});
        en_seen = 1'b0;
        cs_begin();
        send_bits(32'(op), 8);
        send_bits(32'(addr), nbits);
        cs_end();
    endtask

    task automatic status_frame(input logic [7:0] op, input int nbytes);
        logic [7:0] got, expb;
        logic       v;
        bit         en_all;
        cs_begin();
        send_bits(32'(op), 8);
        for (int k = 0; k < nbytes; k++) begin
            expb = {dev_ready, cmp_miss, density, 2'b00};
            en_all = 1'b1;
            for (int i = 0; i < 8; i++) begin
                bit_x(1'b0, v);
                got[7-i] = v;
                if (!so_en) en_all = 1'b0;
                if (k == 0 && i == 3) dev_ready = 1'b0;
                if (k == 1 && i == 5) begin density = 4'b1010; cmp_miss = 1'b1; end
            end
            chk(en_all, "R5 so_en during status", 32'(en_all), 1);
            chk(got == expb, (k == 0) ? "R6 status byte" : "R7 repeated status byte", 32'(got), 32'(expb));
        end
        cs_end();
        chk(so_en == 1'b0, "R5 so_en after cs rise", 32'(so_en), 0);
    endtask

    initial begin
        int c0;
        wclk(3);
        chk(so_en == 1'b0,     "R1 so_en",     32'(so_en), 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 0);
        chk(cs_rise == 1'b0,   "R1 cs_rise",   32'(cs_rise), 0);
        rst_n = 1'b1;
        wclk(5);

        cur_tag = "R2";
        idle_hi = 1'b0; cmd_frame(8'h52, {6'h3F, 9'h1A5, 9'h0F3}, 24, 1'b1);
        idle_hi = 1'b1; cmd_frame(8'hD2, {6'h00, 9'h0C3, 9'h15A}, 24, 1'b1);
        cur_tag = "R4";
        idle_hi = 1'b1; cmd_frame(8'h88, {6'h15, 9'h1FF, 9'h000}, 24, 1'b1);
        idle_hi = 1'b0; cmd_frame(8'h58, {6'h2A, 9'h001, 9'h1FF}, 24, 1'b1);

        idle_hi = 1'b0; status_frame(8'h57, 3);
        dev_ready = 1'b1; cmp_miss = 1'b0; density = 4'b0110;
        idle_hi = 1'b1; status_frame(8'hD7, 2);

        cur_tag = "R8";
        idle_hi = 1'b0; cmd_frame(8'hA5, 24'hFFFFFF, 24, 1'b0);
        chk(!en_seen, "R8 so_en after unknown opcode", 32'(en_seen), 0);

        cur_tag = "R9";
        c0 = n_csr;
        idle_hi = 1'b1; cmd_frame(8'h54, 24'h123456, 10, 1'b0);
        chk(n_csr - c0 == 1, "R10 one cs_rise per frame", 32'(n_csr - c0), 1);
        chk(cmd_opcode == 8'h58, "R11 opcode held", 32'(cmd_opcode), 32'h58);
        chk(cmd_page == 9'h001,  "R11 page held",   32'(cmd_page), 32'h001);

        cur_tag = "R8";
        idle_hi = 1'b1; cmd_frame(8'hD4, {6'h01, 9'h100, 9'h0AA}, 24, 1'b1);
        wclk(20);
        chk(exp_q.size() == 0, "R3 all strobes seen", 32'(exp_q.size()), 0);
        chk(n_csr == 9, "R10 cs_rise count", 32'(n_csr), 9);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule